// File: doc/BRIEF.md
# Serial Flash Clock and Chip-Select Timer

This block produces the serial clock and the active-low chip select for a quad serial flash port. A transfer sequencer asks for a frame with a start strobe and closes it with an end strobe. The block then times the chip-select setup before the first clock edge, runs the clock at a programmable divide of the reference, and times the hold after the last edge. It also keeps chip select high for a minimum time before the next frame. It marks every clock edge with a one-cycle strobe: one for the edge on which data is launched and one for the edge on which data is captured.

The block clock runs at `CLK_PER_REF` times the reference rate. `CLK_PER_REF` is even and defaults to 2, so a 64 MHz block clock stands for a 32 MHz reference. The serial clock period is (div_code+1) reference cycles, which covers 32 MHz down to 2 MHz for a 4-bit code. Two clock modes exist: polarity 0 / phase 0 and polarity 1 / phase 1. In both modes data is captured on the rising edge and launched on the falling edge.

One delay value, cs_delay, sets all three chip-select intervals. It counts ticks of a half-rate reference. A tick is made by enabling every second reference cycle, so it lasts 2*CLK_PER_REF block cycles. The tick prescaler restarts at the start of every interval, so each interval is exact. The divider code, the mode and the delay are captured when a frame starts.

Top module: `flash_sck_cs_timer`

## Requirements
- R1: After reset, csn is 1, shift_stb and sample_stb are 0, and sck equals mode3_sel (0 in the reset test).
- R2: While csn is high, sck follows mode3_sel one cycle later (0 for polarity 0 / phase 0, 1 for polarity 1 / phase 1), and no strobe is raised.
- R3: During a frame, sck toggles every (div_code+1)*CLK_PER_REF/2 block cycles. The full period is (div_code+1) reference cycles.
- R4: With D = max(cs_delay,1)*2*CLK_PER_REF block cycles, the first sck edge comes exactly D cycles after csn falls. On that edge sck leaves its rest level.
- R5: csn rises exactly D cycles after the last sck edge, and sck does not move in the cycle csn rises.
- R6: A start_req that arrives while csn is high after a frame is held. csn then falls exactly D cycles after it rose, with D taken from the frame that just ended. A start_req in the idle state makes csn fall on the next edge.
- R7: sample_stb is high for exactly the cycle in which sck first shows a rising edge. shift_stb is high for exactly the cycle in which sck first shows a falling edge.
- R8: A frame ends on the first sck edge that returns sck to its rest level at or after an end_req. An end_req given before the first edge yields exactly one clock period.
- R9: A cs_delay of 0 times each interval as one tick (2*CLK_PER_REF block cycles).
- R10: start_req is ignored while csn is low, and end_req is ignored while csn is high.
- R11: Changing div_code or cs_delay while csn is low has no effect on the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, CLK_PER_REF times the reference rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_code | input | DIV_W | Clock divide code; period is div_code+1 reference cycles |
| mode3_sel | input | 1 | 0: polarity 0 / phase 0, 1: polarity 1 / phase 1 |
| cs_delay | input | DLY_W | Chip-select interval in half-rate reference ticks (0 means 1) |
| start_req | input | 1 | One-cycle request to open a frame |
| end_req | input | 1 | One-cycle request to close the frame |
| sck | output | 1 | Serial clock |
| csn | output | 1 | Active-low chip select |
| shift_stb | output | 1 | One-cycle strobe on each falling sck edge |
| sample_stb | output | 1 | One-cycle strobe on each rising sck edge |

## Verification
Several properties are checked on every cycle. Each strobe must match an sck transition in its direction. No strobe may appear while deselected. sck must be still when csn rises. The setup, hold and deassert intervals must each last at least one tick. The exact interval lengths under each divider code and delay, the count of periods before an end request closes the frame, and the capture of configuration at frame start can only be shown by the bench scenarios, which compare every cycle of a frame with a computed waveform.

// File: rtl/sct_pkg.sv
package sct_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_SETUP = 3'd1,
      ST_RUN   = 3'd2,
      ST_HOLD  = 3'd3,
      ST_GAP   = 3'd4
   } sct_state_e;

   // Tick count actually timed for a delay value: zero is raised to one.
   function automatic int unsigned sct_eff_ticks(input int unsigned dly);
      return (dly == 0) ? 1 : dly;
   endfunction

endpackage

// File: rtl/sct_interval_timer.sv
module sct_interval_timer #(
   parameter int DLY_W       = 8,
   parameter int CLK_PER_REF = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             run,
   input  logic [DLY_W-1:0] dly,
   output logic             done
);
   localparam int TICK_CYC = 2 * CLK_PER_REF;
   localparam int PW       = $clog2(TICK_CYC);
   localparam logic [PW-1:0] P_LAST = PW'(TICK_CYC - 1);

   logic [PW-1:0]    pre_q;
   logic [DLY_W-1:0] tick_q;
   logic             tick;

   assign tick = run && (pre_q == P_LAST);
   assign done = tick && (tick_q == DLY_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q  <= '0;
         tick_q <= DLY_W'(1);
      end else if (load) begin
         pre_q  <= '0;
         tick_q <= (dly == '0) ? DLY_W'(1) : dly;
      end else if (run) begin
         pre_q <= (pre_q == P_LAST) ? '0 : pre_q + PW'(1);
         if (tick && (tick_q != DLY_W'(1))) begin
            tick_q <= tick_q - DLY_W'(1);
         end
      end
   end

endmodule

// File: rtl/sct_sck_gen.sv
module sct_sck_gen #(
   parameter int DIV_W       = 4,
   parameter int CLK_PER_REF = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   input  logic             launch,
   input  logic             active,
   input  logic             frame_pol,
   input  logic             rest_pol,
   output logic             sck,
   output logic             sample_stb,
   output logic             shift_stb,
   output logic             toggle,
   output logic             next_lvl
);
   localparam int HALF_UNIT = CLK_PER_REF / 2;
   localparam int HMAX      = (1 << DIV_W) * HALF_UNIT;
   localparam int HW        = (HMAX > 1) ? $clog2(HMAX) : 1;

   logic [HW-1:0] half_m1;
   logic [HW-1:0] hcnt_q;
   logic          sck_q;
   logic          smp_q;
   logic          sft_q;

   generate
      if (HALF_UNIT == 1) begin : g_direct
         assign half_m1 = HW'(div);
      end else begin : g_scaled
         logic [31:0] prod;
         assign prod    = (32'(div) + 32'd1) * 32'(HALF_UNIT) - 32'd1;
         assign half_m1 = prod[HW-1:0];
      end
   endgenerate

   assign toggle   = launch || (active && (hcnt_q == '0));
   assign next_lvl = launch ? ~frame_pol : ~sck_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q  <= 1'b0;
         hcnt_q <= '0;
         smp_q  <= 1'b0;
         sft_q  <= 1'b0;
      end else begin
         smp_q <= toggle && next_lvl;
         sft_q <= toggle && !next_lvl;
         if (launch) begin
            sck_q  <= ~frame_pol;
            hcnt_q <= half_m1;
         end else if (active) begin
            if (hcnt_q == '0) begin
               sck_q  <= ~sck_q;
               hcnt_q <= half_m1;
            end else begin
               hcnt_q <= hcnt_q - HW'(1);
            end
         end else begin
            sck_q  <= rest_pol;
            hcnt_q <= '0;
         end
      end
   end

   assign sck        = sck_q;
   assign sample_stb = smp_q;
   assign shift_stb  = sft_q;

endmodule

// File: rtl/flash_sck_cs_timer.sv
module flash_sck_cs_timer
   import sct_pkg::*;
#(
   parameter int DIV_W       = 4,
   parameter int DLY_W       = 8,
   parameter int CLK_PER_REF = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_code,
   input  logic             mode3_sel,
   input  logic [DLY_W-1:0] cs_delay,
   input  logic             start_req,
   input  logic             end_req,
   output logic             sck,
   output logic             csn,
   output logic             shift_stb,
   output logic             sample_stb
);
   generate
      if ((CLK_PER_REF < 2) || ((CLK_PER_REF % 2) != 0)) begin : g_bad_ratio
         $error("CLK_PER_REF must be even and at least 2");
      end
      if ((DIV_W < 1) || (DLY_W < 1)) begin : g_bad_width
         $error("DIV_W and DLY_W must be at least 1");
      end
   endgenerate

   sct_state_e       state_q, state_d;
   logic             csn_q, csn_d;
   logic             start_pend_q, start_pend_d;
   logic             end_pend_q, end_pend_d;
   logic [DIV_W-1:0] div_q;
   logic [DLY_W-1:0] dly_q;
   logic             cpol_q;
   logic             capture;
   logic             tmr_load;
   logic             tmr_run;
   logic             tmr_done;
   logic             launch;
   logic             toggle;
   logic             next_lvl;
   logic             rest_pol;
   logic             to_rest;

   assign tmr_run  = (state_q == ST_SETUP) || (state_q == ST_HOLD) || (state_q == ST_GAP);
   assign rest_pol = csn_q ? mode3_sel : cpol_q;
   assign to_rest  = toggle && (next_lvl == cpol_q);

   always_comb begin
      state_d      = state_q;
      csn_d        = csn_q;
      start_pend_d = start_pend_q;
      end_pend_d   = end_pend_q;
      capture      = 1'b0;
      tmr_load     = 1'b0;
      launch       = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (start_req) begin
               state_d    = ST_SETUP;
               csn_d      = 1'b0;
               capture    = 1'b1;
               tmr_load   = 1'b1;
               end_pend_d = 1'b0;
            end
         end
         ST_SETUP: begin
            if (end_req) end_pend_d = 1'b1;
            if (tmr_done) begin
               state_d = ST_RUN;
               launch  = 1'b1;
            end
         end
         ST_RUN: begin
            if (to_rest && (end_pend_q || end_req)) begin
               state_d    = ST_HOLD;
               tmr_load   = 1'b1;
               end_pend_d = 1'b0;
            end else if (end_req) begin
               end_pend_d = 1'b1;
            end
         end
         ST_HOLD: begin
            if (tmr_done) begin
               state_d  = ST_GAP;
               csn_d    = 1'b1;
               tmr_load = 1'b1;
            end
         end
         ST_GAP: begin
            if (start_req) start_pend_d = 1'b1;
            if (tmr_done) begin
               if (start_pend_q || start_req) begin
                  state_d      = ST_SETUP;
                  csn_d        = 1'b0;
                  capture      = 1'b1;
                  tmr_load     = 1'b1;
                  start_pend_d = 1'b0;
                  end_pend_d   = 1'b0;
               end else begin
                  state_d = ST_IDLE;
               end
            end
         end
         default: begin
            state_d = ST_IDLE;
            csn_d   = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         csn_q        <= 1'b1;
         start_pend_q <= 1'b0;
         end_pend_q   <= 1'b0;
         div_q        <= '0;
         dly_q        <= '0;
         cpol_q       <= 1'b0;
      end else begin
         state_q      <= state_d;
         csn_q        <= csn_d;
         start_pend_q <= start_pend_d;
         end_pend_q   <= end_pend_d;
         if (capture) begin
            div_q  <= div_code;
            dly_q  <= cs_delay;
            cpol_q <= mode3_sel;
         end
      end
   end

   sct_interval_timer #(
      .DLY_W       (DLY_W),
      .CLK_PER_REF (CLK_PER_REF)
   ) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (tmr_load),
      .run   (tmr_run),
      .dly   (capture ? cs_delay : dly_q),
      .done  (tmr_done)
   );

   sct_sck_gen #(
      .DIV_W       (DIV_W),
      .CLK_PER_REF (CLK_PER_REF)
   ) u_sck (
      .clk        (clk),
      .rst_n      (rst_n),
      .div        (div_q),
      .launch     (launch),
      .active     (state_q == ST_RUN),
      .frame_pol  (cpol_q),
      .rest_pol   (rest_pol),
      .sck        (sck),
      .sample_stb (sample_stb),
      .shift_stb  (shift_stb),
      .toggle     (toggle),
      .next_lvl   (next_lvl)
   );

   assign csn = csn_q;

endmodule

// File: rtl/flash_sck_cs_timer_chk.sv
module flash_sck_cs_timer_chk #(
   parameter int CLK_PER_REF = 2
) (
   input logic clk,
   input logic rst_n,
   input logic sck,
   input logic csn,
   input logic shift_stb,
   input logic sample_stb
);
   localparam int TICK_CYC = 2 * CLK_PER_REF;
   localparam int CW       = 12;
   localparam logic [CW-1:0] CMAX = {CW{1'b1}};

   logic [CW-1:0] lo_cnt;
   logic [CW-1:0] hi_cnt;
   logic [CW-1:0] since_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_cnt     <= '0;
         hi_cnt     <= CMAX;
         since_edge <= CMAX;
      end else begin
         lo_cnt     <= csn ? '0 : ((lo_cnt == CMAX) ? CMAX : lo_cnt + CW'(1));
         hi_cnt     <= !csn ? '0 : ((hi_cnt == CMAX) ? CMAX : hi_cnt + CW'(1));
         since_edge <= (shift_stb || sample_stb) ? '0 :
                       ((since_edge == CMAX) ? CMAX : since_edge + CW'(1));
      end
   end

   AST_SAMPLE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      sample_stb |-> (sck && !$past(sck))); // R7
   AST_SHIFT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      shift_stb |-> (!sck && $past(sck))); // R7
   AST_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      csn |-> (!shift_stb && !sample_stb)); // R2
   AST_SCK_STILL_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(csn) |-> $stable(sck)); // R5
   AST_SETUP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      (shift_stb || sample_stb) |-> (lo_cnt >= CW'(TICK_CYC))); // R4
   AST_HOLD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(csn) |-> (since_edge >= CW'(TICK_CYC - 1))); // R5
   AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(csn) |-> (hi_cnt >= CW'(TICK_CYC))); // R6

endmodule

bind flash_sck_cs_timer flash_sck_cs_timer_chk #(
   .CLK_PER_REF (CLK_PER_REF)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sck        (sck),
   .csn        (csn),
   .shift_stb  (shift_stb),
   .sample_stb (sample_stb)
);

// File: tb/flash_sck_cs_timer_tb.sv
module flash_sck_cs_timer_tb;
   localparam int CPR = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] div_code = '0;
   logic       mode3_sel = 1'b0;
   logic [7:0] cs_delay = '0;
   logic       start_req = 1'b0;
   logic       end_req = 1'b0;
   logic       sck, csn, shift_stb, sample_stb;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   flash_sck_cs_timer #(.DIV_W(4), .DLY_W(8), .CLK_PER_REF(CPR)) u_dut (
      .clk(clk), .rst_n(rst_n), .div_code(div_code), .mode3_sel(mode3_sel),
      .cs_delay(cs_delay), .start_req(start_req), .end_req(end_req),
      .sck(sck), .csn(csn), .shift_stb(shift_stb), .sample_stb(sample_stb));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int dcyc(input int dly);
      return ((dly == 0) ? 1 : dly) * 2 * CPR;
   endfunction

   function automatic int hcyc(input int code);
      return (code + 1) * (CPR / 2);
   endfunction

   // Checks one frame cycle by cycle. On entry with from_chain set, the
   // current sample is the first one with csn low.
   task automatic run_frame(input int code, input bit mode, input int dly, input int k,
                            input bit early_end, input bit from_chain,
                            input bit chain_next, input int n_code, input bit n_mode,
                            input int n_dly);
      int d, h, l, ld, end_at;
      d  = dcyc(dly);
      h  = hcyc(code);
      l  = d + (2 * k - 1) * h;
      ld = l + d;
      end_at = (early_end && k == 1) ? 0 : l - 1;
      if (!from_chain) begin
         div_code  = 4'(code);
         mode3_sel = mode;
         cs_delay  = 8'(dly);
         @(negedge clk);
         @(negedge clk);
         start_req = 1'b1;
         @(negedge clk);
      end
      for (int i = 0; i <= ld; i++) begin
         bit e_csn, e_sck, e_smp, e_sft;
         int j;
         if (i > 0) @(negedge clk);
         e_csn = (i < ld) ? 1'b0 : 1'b1;
         e_smp = 1'b0;
         e_sft = 1'b0;
         if (i < d) begin
            e_sck = mode;
         end else begin
            j = (i - d) / h;
            if (j > 2 * k - 1) j = 2 * k - 1;
            e_sck = (j % 2 == 0) ? ~mode : mode;
            if (((i - d) % h == 0) && ((i - d) / h <= 2 * k - 1)) begin
               e_smp = e_sck;
               e_sft = ~e_sck;
            end
         end
         // R4 R5 R8 R9 R10 R11: chip-select window and frame length
         chk(csn == e_csn, "R5 csn window", csn, e_csn);
         // R3 R4 R8: clock waveform
         chk(sck == e_sck, "R3 sck level", sck, e_sck);
         // R7: strobes
         chk(sample_stb == e_smp, "R7 sample_stb", sample_stb, e_smp);
         chk(shift_stb == e_sft, "R7 shift_stb", shift_stb, e_sft);
         if (i == 0) start_req = 1'b0;
         if (i == 1) begin
            div_code = 4'($urandom_range(0, 15));   // R11 mid-frame change
            cs_delay = 8'($urandom_range(0, 255));
         end
         if (i == 2) start_req = 1'b1;              // R10 ignored while selected
         if (i == 3) start_req = 1'b0;
         end_req = (i == end_at);
      end
      end_req = 1'b0;
      if (chain_next) begin
         div_code  = 4'(n_code);
         mode3_sel = n_mode;
         cs_delay  = 8'(n_dly);
         start_req = 1'b1;                           // R6 held during gap
         for (int m = 1; m < d; m++) begin
            @(negedge clk);
            if (m == 1) start_req = 1'b0;
            chk(csn == 1'b1, "R6 gap held", csn, 1);
            chk(!sample_stb && !shift_stb, "R2 quiet in gap", sample_stb, 0);
         end
         @(negedge clk);
         start_req = 1'b0;
         chk(csn == 1'b0, "R6 gap end", csn, 0);
      end else begin
         for (int m = 1; m <= d + 3; m++) begin
            @(negedge clk);
            end_req = (m == 2);                      // R10 ignored while deselected
            chk(csn == 1'b1, "R10 stays deselected", csn, 1);
            chk(sck == mode, "R2 rest level", sck, mode);
         end
         end_req = 1'b0;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int code, dly, k, n_code, n_dly, n_k;
      bit mode, n_mode, chain, from_chain, early;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      chk(csn == 1'b1, "R1 reset csn", csn, 1);
      chk(sck == 1'b0, "R1 reset sck", sck, 0);
      chk(!sample_stb && !shift_stb, "R1 reset strobes", sample_stb | shift_stb, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(csn == 1'b1, "R1 after reset csn", csn, 1);
      // R2: rest level follows mode while deselected
      mode3_sel = 1'b1;
      repeat (2) @(negedge clk);
      chk(sck == 1'b1, "R2 rest high", sck, 1);
      mode3_sel = 1'b0;
      repeat (2) @(negedge clk);
      chk(sck == 1'b0, "R2 rest low", sck, 0);

      // Directed corners
      run_frame(0, 1'b0, 0, 3, 1'b0, 1'b0, 1'b0, 0, 1'b0, 0);   // R9 fastest
      run_frame(0, 1'b1, 0, 1, 1'b1, 1'b0, 1'b0, 0, 1'b0, 0);   // R8 early end
      run_frame(15, 1'b0, 255, 2, 1'b0, 1'b0, 1'b1, 3, 1'b1, 2);// R6 chained
      run_frame(3, 1'b1, 2, 2, 1'b0, 1'b1, 1'b0, 0, 1'b0, 0);
      run_frame(4, 1'b0, 1, 1, 1'b1, 1'b0, 1'b0, 0, 1'b0, 0);   // R3 odd divide

      // Constrained random frames
      code = $urandom_range(0, 15);
      mode = 1'($urandom_range(0, 1));
      dly  = ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(1, 10);
      k    = $urandom_range(1, 4);
      from_chain = 1'b0;
      for (int n = 0; n < 24; n++) begin
         n_code = $urandom_range(0, 15);
         n_mode = 1'($urandom_range(0, 1));
         n_dly  = ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(1, 10);
         n_k    = $urandom_range(1, 4);
         chain  = (n < 23) && ($urandom_range(0, 1) == 1);
         early  = ($urandom_range(0, 1) == 1);
         run_frame(code, mode, dly, k, early, from_chain, chain, n_code, n_mode, n_dly);
         from_chain = chain;
         code = n_code; mode = n_mode; dly = n_dly; k = n_k;
      end

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule